// File: doc/BRIEF.md
# DMA Channel Request and Enable Controller

This block holds the control state of one DMA channel. It picks one peripheral request line from a bank of interrupt-request flags, or takes a software trigger, and records the event in a pending flag. When the channel is enabled and a request is pending, it issues a one-cycle transfer-start strobe. It then waits for the completion handshake and advances the transfer counter and the forward-moving address pointer. The bus datapath and arbitration between channels sit outside. A chip with two channels instantiates the block twice.

Software programs the channel through a small register port. Writing 1 to the enable bit puts the channel into its initial state: the counter is loaded from its reload register, and the pointer is loaded from whichever address register counts forward. Only hardware can set the pending flag. Software can only clear it, and the block clears it itself as a transfer starts.

Register map: 0 control, 1 select, 2 source address, 3 destination address, 4 counter reload, 5 current pointer (read only), 6 current count (read only). Control bits: 0 enable, 1 pending, 2 word unit (1 = 2 bytes, 0 = 1 byte), 3 source forward, 4 destination forward. Select bits: 3:0 line select, 4 bank, 5 software trigger (write 1 to fire, reads 0).

Top module: `dma_chan_ctrl`

## Requirements
- R1: A rising edge on the selected request line sets the pending flag (control bit 1) at the next clock edge, whatever the state of the enable bit.
- R2: A request line held high gives one request only. After software clears the flag, the flag stays 0 while the line remains high.
- R3: A software write of 1 to the pending bit has no effect. A write of 0 clears it.
- R4: If a hardware request and a software clear of the pending flag fall in the same cycle, the flag ends up set.
- R5: If the channel is enabled and a request is pending, `xfer_start` pulses for exactly one cycle at the next edge and the pending flag clears at that same edge. No further start is issued until `xfer_done` is seen.
- R6: The selected line is index bank*16 + select. Lines that are not selected are ignored. Writing select bit 5 as 1 raises a request.
- R7: A control write with bit 0 set loads the counter from the reload register, also when the channel is already enabled.
- R8: That write loads the pointer from the source address if bit 3 of the written value is 1. Otherwise it loads the destination address if bit 4 is 1. If neither bit is set, the pointer is left unchanged.
- R9: Each `xfer_done` while a transfer is in progress decrements the counter by 1 and advances the pointer by 1 (bit 2 = 0) or 2 (bit 2 = 1).
- R10: When the counter reaches 0, the enable bit clears and `xfer_tc` pulses for one cycle.
- R11: A control write that sets enable and pending together, in the same cycle as a request edge, still reloads the counter and pointer, and leaves the pending flag set.
- R12: After reset, every register, the pending flag, `xfer_start` and `xfer_tc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| per_req | input | 32 | Peripheral request lines, two banks of 16 |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_addr | output | 20 | Current forward address pointer |
| xfer_wide | output | 1 | Transfer unit is 2 bytes |
| xfer_done | input | 1 | Transfer completion handshake |
| xfer_tc | output | 1 | One-cycle terminal-count pulse |

## Verification
Register writes and request edges take effect at the next rising edge, so the pending flag, counter and pointer are read back at the falling edge right after that edge. A pending request on an enabled channel gives `xfer_start` one edge later, and the bench samples it at the following falling edge, together with the cleared pending flag. `xfer_done` is driven for one cycle. The decremented count, the advanced pointer and `xfer_tc` are all checked one falling edge after the edge that samples it. Every check lands on the half-cycle after the edge that settles the result.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_SEL    = 3'd1,
    RA_SRC    = 3'd2,
    RA_DST    = 3'd3,
    RA_RELOAD = 3'd4,
    RA_PTR    = 3'd5,
    RA_CNT    = 3'd6
  } reg_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_PEND = 1;
  localparam int CB_WIDE = 2;
  localparam int CB_SFWD = 3;
  localparam int CB_DFWD = 4;

  // pointer advance per completed transfer
  function automatic logic [31:0] ptr_step(input logic [31:0] p, input logic wide);
    return p + (wide ? 32'd2 : 32'd1);
  endfunction

  // pointer value chosen on an enable write
  function automatic logic [31:0] ptr_pick(input logic sfwd, input logic [31:0] src,
                                           input logic [31:0] dst);
    return sfwd ? src : dst;
  endfunction
endpackage

// File: rtl/dmac_req_sel.sv
module dmac_req_sel #(
  parameter int IDX_W = 5,
  localparam int N_LINES = 2 ** IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] per_req,
  input  logic [IDX_W-1:0]   idx,
  input  logic               soft_trig,
  output logic               line_rise,
  output logic               hw_set
);
  logic line;
  logic prev_q;

  assign line = per_req[idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line;

  assign line_rise = line & ~prev_q;
  assign hw_set    = line_rise | soft_trig;

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |=> !line_rise); // R2
endmodule

// File: rtl/dmac_pend.sv
module dmac_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic start_fire,
  output logic pend
);
  logic pend_q;
  logic sw_clr;

  assign sw_clr = sw_wr & ~sw_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    pend_q <= 1'b0;
    else if (hw_set)               pend_q <= 1'b1;
    else if (sw_clr || start_fire) pend_q <= 1'b0;

  assign pend = pend_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> pend_q); // R1
  AST_SW_SET_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_val && !hw_set && !pend_q) |=> !pend_q); // R3
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && !hw_set) |=> !pend_q); // R5
endmodule

// File: rtl/dmac_xfer_ctr.sv
module dmac_xfer_ctr #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_ptr,
  input  logic [ADDR_W-1:0] ptr_init,
  input  logic [CNT_W-1:0]  reload,
  input  logic              step,
  input  logic              wide,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              last
);
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign last = step & ~load & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload;
      if (load_ptr) ptr_q <= ptr_init;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
      ptr_q <= ADDR_W'(dmac_pkg::ptr_step(32'(ptr_q), wide));
    end

  assign ptr = ptr_q;
  assign cnt = cnt_q;

  AST_LOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload))); // R7
  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R9
  AST_LAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int N_PER  = 16,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int SEL_W   = $clog2(N_PER),
  localparam int IDX_W   = SEL_W + 1,
  localparam int N_LINES = 2 * N_PER,
  localparam int SB_BANK = SEL_W,
  localparam int SB_SOFT = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [2:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [N_LINES-1:0] per_req,
  output logic               xfer_start,
  output logic [ADDR_W-1:0]  xfer_addr,
  output logic               xfer_wide,
  input  logic               xfer_done,
  output logic               xfer_tc
);
  import dmac_pkg::*;

  logic              en_q, wide_q, sfwd_q, dfwd_q, bank_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  reload_q;
  logic              busy_q, start_q, tc_q;

  // named internal events
  logic wr_ctrl, wr_sel, enable_wr, soft_trig, start_fire, step, last;
  logic line_rise, hw_set, pend;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;

  assign wr_ctrl    = wr_en && (wr_addr == RA_CTRL);
  assign wr_sel     = wr_en && (wr_addr == RA_SEL);
  assign enable_wr  = wr_ctrl && wr_data[CB_EN];
  assign soft_trig  = wr_sel && wr_data[SB_SOFT];
  assign start_fire = en_q && pend && !busy_q;
  assign step       = xfer_done && busy_q;

  dmac_req_sel #(.IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .idx({bank_q, sel_q}),
    .soft_trig(soft_trig), .line_rise(line_rise), .hw_set(hw_set)
  );

  dmac_pend u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_wr(wr_ctrl),
    .sw_val(wr_data[CB_PEND]), .start_fire(start_fire), .pend(pend)
  );

  dmac_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(enable_wr),
    .load_ptr(wr_data[CB_SFWD] | wr_data[CB_DFWD]),
    .ptr_init(ADDR_W'(ptr_pick(wr_data[CB_SFWD], 32'(src_q), 32'(dst_q)))),
    .reload(reload_q), .step(step), .wide(wide_q),
    .ptr(ptr), .cnt(cnt), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; wide_q <= 1'b0; sfwd_q <= 1'b0; dfwd_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wr_data[CB_EN];
      wide_q <= wr_data[CB_WIDE];
      sfwd_q <= wr_data[CB_SFWD];
      dfwd_q <= wr_data[CB_DFWD];
    end else if (last) begin
      en_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; bank_q <= 1'b0;
      src_q <= '0; dst_q <= '0; reload_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_SEL:    begin sel_q <= wr_data[SEL_W-1:0]; bank_q <= wr_data[SB_BANK]; end
        RA_SRC:    src_q    <= wr_data[ADDR_W-1:0];
        RA_DST:    dst_q    <= wr_data[ADDR_W-1:0];
        RA_RELOAD: reload_q <= wr_data[CNT_W-1:0];
        default:   ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; start_q <= 1'b0; tc_q <= 1'b0;
    end else begin
      start_q <= start_fire;
      tc_q    <= last;
      if (start_fire) busy_q <= 1'b1;
      else if (step)  busy_q <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[CB_EN]   = en_q;
        rd_data[CB_PEND] = pend;
        rd_data[CB_WIDE] = wide_q;
        rd_data[CB_SFWD] = sfwd_q;
        rd_data[CB_DFWD] = dfwd_q;
      end
      RA_SEL: begin
        rd_data[SEL_W-1:0] = sel_q;
        rd_data[SB_BANK]   = bank_q;
      end
      RA_SRC:    rd_data = DATA_W'(src_q);
      RA_DST:    rd_data = DATA_W'(dst_q);
      RA_RELOAD: rd_data = DATA_W'(reload_q);
      RA_PTR:    rd_data = DATA_W'(ptr);
      RA_CNT:    rd_data = DATA_W'(cnt);
      default:   rd_data = '0;
    endcase
  end

  assign xfer_start = start_q;
  assign xfer_addr  = ptr;
  assign xfer_wide  = wide_q;
  assign xfer_tc    = tc_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q); // R5
  AST_TC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> !en_q); // R10
  AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q); // R10
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_P = 10;
  localparam logic [19:0] AMASK = 20'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] per_req = '0;
  logic        xfer_start;
  logic [19:0] xfer_addr;
  logic        xfer_wide;
  logic        xfer_done = 1'b0;
  logic        xfer_tc;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .per_req(per_req), .xfer_start(xfer_start),
    .xfer_addr(xfer_addr), .xfer_wide(xfer_wide), .xfer_done(xfer_done), .xfer_tc(xfer_tc)
  );

  function automatic int line_of(input int bank, input int sel);
    return bank * 16 + sel;
  endfunction

  function automatic logic [19:0] ptr_after(input logic [19:0] base, input logic wide, input int n);
    return (base + 20'(n * (wide ? 2 : 1))) & AMASK;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_pend(input logic exp, input string req);
    logic [31:0] v;
    rd(3'd0, v);
    chk(v[1] == exp, req, v[1], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(3'd0, v); chk(v == 0, "R12 ctrl", v, 0);
    rd(3'd6, v); chk(v == 0, "R12 cnt", v, 0);
    rd(3'd5, v); chk(v == 0, "R12 ptr", v, 0);
    chk(xfer_start == 0 && xfer_tc == 0, "R12 strobes", {xfer_start, xfer_tc}, 0);

    // R1: select bank 1 line 5, channel disabled
    wr(3'd1, 32'h15);
    wr(3'd0, 32'h0);
    per_req[line_of(1, 5)] = 1'b1;
    @(negedge clk);
    chk_pend(1'b1, "R1 set while disabled");
    // R2: level held high, clear, stays clear
    wr(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk_pend(1'b0, "R2 held level no repeat");
    per_req = '0;
    @(negedge clk);

    // R6: unselected line ignored
    per_req[line_of(0, 5)] = 1'b1;
    @(negedge clk);
    chk_pend(1'b0, "R6 unselected line");
    per_req = '0;
    @(negedge clk);

    // R3: software write of 1 ignored
    wr(3'd0, 32'h2);
    chk_pend(1'b0, "R3 sw set ignored");

    // R6: software trigger
    wr(3'd1, 32'h35);
    chk_pend(1'b1, "R6 soft trigger");
    rd(3'd1, v); chk(v[5] == 0, "R6 trigger reads 0", v[5], 0);

    // R3: software clear
    wr(3'd0, 32'h0);
    chk_pend(1'b0, "R3 sw clear");

    // R4: hw set and sw clear in the same cycle
    per_req[line_of(1, 5)] = 1'b1;
    wr(3'd0, 32'h0);
    chk_pend(1'b1, "R4 hw wins");
    per_req = '0;
    wr(3'd0, 32'h0);

    // R11 / R7 / R8: enable+pending write with a coincident request
    wr(3'd2, 32'h100);
    wr(3'd3, 32'h2000);
    wr(3'd4, 32'd3);
    per_req[line_of(1, 5)] = 1'b1;
    wr(3'd0, 32'h0B);  // en, pend, sfwd
    rd(3'd6, v); chk(v == 3, "R11 counter reload", v, 3);
    rd(3'd5, v); chk(v == 32'h100, "R8 ptr from src", v, 32'h100);
    chk_pend(1'b1, "R11 pending kept");
    @(negedge clk);
    chk(xfer_start == 1, "R5 start strobe", xfer_start, 1);
    chk_pend(1'b0, "R5 pending cleared at start");
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(xfer_start == 0, "R5 one-cycle start", xfer_start, 0);
    rd(3'd6, v); chk(v == 2, "R9 decrement", v, 2);
    rd(3'd5, v); chk(v == 32'h101, "R9 byte step", v, 32'h101);
    chk(xfer_tc == 0, "R10 no early tc", xfer_tc, 0);
    // R7: enable again while enabled reloads
    wr(3'd0, 32'h11); // en, dfwd
    rd(3'd6, v); chk(v == 3, "R7 re-enable reload", v, 3);
    rd(3'd5, v); chk(v == 32'h2000, "R8 ptr from dst", v, 32'h2000);
    wr(3'd0, 32'h1);  // neither forward
    rd(3'd5, v); chk(v == 32'h2000, "R8 ptr unchanged", v, 32'h2000);
    wr(3'd0, 32'h0);
    per_req = '0;
    @(negedge clk);

    // constrained random runs
    for (int it = 0; it < 20; it++) begin
      int n = 1 + int'($urandom % 4);
      logic wide = 1'($urandom);
      logic sfwd = 1'($urandom);
      int sel = int'($urandom % 16);
      int bank = int'($urandom % 2);
      logic [19:0] src = 20'($urandom);
      logic [19:0] dst = 20'($urandom);
      logic [19:0] base = sfwd ? src : dst;
      wr(3'd1, 32'(bank * 16 + sel));
      wr(3'd0, 32'h0);
      chk_pend(1'b0, "R3 clear after select change");
      wr(3'd2, 32'(src));
      wr(3'd3, 32'(dst));
      wr(3'd4, 32'(n));
      wr(3'd0, {27'd0, ~sfwd, sfwd, wide, 2'b01});
      rd(3'd6, v); chk(v == 32'(n), "R7 random reload", v, n);
      for (int k = 0; k < n; k++) begin
        if ($urandom % 2 == 0) begin
          wr(3'd1, 32'(bank * 16 + sel) | 32'h20);
        end else begin
          per_req[line_of(bank, sel)] = 1'b1;
          @(negedge clk);
          per_req = '0;
        end
        chk_pend(1'b1, "R1 random request");
        @(negedge clk);
        chk(xfer_start == 1, "R5 random start", xfer_start, 1);
        chk(xfer_addr == ptr_after(base, wide, k), "R9 random ptr", xfer_addr,
            ptr_after(base, wide, k));
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(xfer_tc == (k == n - 1), "R10 tc pulse", xfer_tc, (k == n - 1));
        rd(3'd6, v); chk(v == 32'(n - k - 1), "R9 random count", v, n - k - 1);
      end
      rd(3'd0, v); chk(v[0] == 0, "R10 enable cleared", v[0], 0);
      rd(3'd5, v); chk(v[19:0] == ptr_after(base, wide, n), "R9 final ptr", v,
                        ptr_after(base, wide, n));
      @(negedge clk);
      chk(xfer_tc == 0, "R10 tc one cycle", xfer_tc, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule